// File: doc/BRIEF.md
# Four-Slot ADC Conversion Sequencer

This block is the digital front end of a successive-approximation converter. Software writes an 8-bit control byte, and the block then runs a pass of four conversions. It hands each channel number to the converter core, collects the results and files them into four read-only result slots. The pass either stops after the fourth slot or repeats forever, wrapping back to slot 1. A sticky completion flag reports that all four slots hold results from the current command.

A new control write at any time drops whatever is running and starts again from slot 1. A low-power request holds the sequence. A result that was in flight when the request arrived is thrown away, and the same channel is converted again once the request is withdrawn. The converter core is outside the block and is reached through a plain start, busy, done and data handshake.

The bus side has no back-pressure. A write is taken in the cycle `bus_wr` is high, and read data is combinational from `bus_addr`. The converter side has no back-pressure either: the block takes `cv_done` in whatever cycle it arrives, and the core must not be started again until it drops `cv_busy`.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the control byte (address 0) and all four result slots (addresses 1 to 4) read 0, and no conversion starts until the control byte is written.
- R2: Address 0 reads {flag, 0, scan, multi, sel[3:0]}, with the flag at bit 7, a constant 0 at bit 6, scan at bit 5, multi at bit 4 and the channel select at bits 3:0. Bits 5:0 return the last written value, and write data in bits 7:6 has no effect.
- R3: A write to address 0 clears the flag and starts a new pass at slot 1. This holds even while a pass is running, and a result of the aborted pass that arrives afterwards is not stored.
- R4: With scan = 0 the block performs exactly four conversions, storing the k-th result in slot k (address k). It then starts nothing more until the next control write.
- R5: With scan = 1 conversions continue without end. The fifth result replaces slot 1, the sixth replaces slot 2, and so on in cycle.
- R6: The flag sets when the fourth result of a pass is stored. In scan mode it stays set until the next control write.
- R7: With multi = 0 every conversion uses channel sel[3:0]. With multi = 1 the channel is {sel[3:2], slot index}, so the pass steps through channels 4g, 4g+1, 4g+2, 4g+3.
- R8: `cv_start` is a one-cycle pulse, raised only while `cv_busy` is low. A `cv_done` result is stored only while the block is waiting on a conversion it started.
- R9: While `lp_req` is high no conversion starts and any arriving result is discarded. When `lp_req` falls, the same slot and channel are converted again.
- R10: Writes to addresses other than 0 change neither the result slots nor the control byte, and they start nothing. Addresses above 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 3 | Register address: 0 control, 1..4 result slots |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| lp_req | input | 1 | Low-power request, level sensitive |
| cv_start | output | 1 | One-cycle conversion start to the core |
| cv_chan | output | 4 | Channel to sample, valid with cv_start |
| cv_busy | input | 1 | Core is converting |
| cv_done | input | 1 | One-cycle result strobe from the core |
| cv_data | input | 8 | Conversion result, valid with cv_done |

## Verification
The assertions rely on the converter core honouring its side of the handshake. The core raises `cv_busy` in the cycle after `cv_start` and holds it until it pulses `cv_done` once, so a start can never overlap a conversion still in flight. The bench's converter model has a fixed latency of twelve cycles and keeps exactly this discipline. Bus writes and `lp_req` changes are driven on the falling edge, so each is seen cleanly at a single rising edge. The abort and low-power steps are timed against that fixed latency so that they always land while a conversion is in flight.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SUSP  = 2'd3
  } seq_state_t;

  localparam int CTL_ADDR = 0;
endpackage

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg #(
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int CHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic           pass_done,
  output logic           ctl_wr,
  output logic           scan,
  output logic           mult,
  output logic [CHW-1:0] csel,
  output logic           flag
);
  import adc_seq_pkg::*;

  assign ctl_wr = wr_en && (addr == AW'(CTL_ADDR));

  // bits 5:4 are mode, CHW-1:0 select; bits 7:6 of write data are dropped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan <= 1'b0;
      mult <= 1'b0;
      csel <= '0;
      flag <= 1'b0;
    end else if (ctl_wr) begin
      scan <= wdata[5];
      mult <= wdata[4];
      csel <= wdata[CHW-1:0];
      flag <= 1'b0;
    end else if (pass_done) begin
      flag <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int CHW   = 4,
  parameter int NSLOT = 4,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic           scan,
  input  logic           mult,
  input  logic [CHW-1:0] csel,
  input  logic           lp_req,
  input  logic           cv_busy,
  input  logic           cv_done,
  output logic           cv_start,
  output logic [CHW-1:0] cv_chan,
  output logic [SW-1:0]  slot,
  output logic           slot_we,
  output logic           pass_done
);
  import adc_seq_pkg::*;

  seq_state_t state;
  logic       last_slot;
  logic       accept;

  assign last_slot = (slot == SW'(NSLOT - 1));
  // a result counts only when waiting, awake and not being aborted
  assign accept    = (state == ST_WAIT) && cv_done && !lp_req && !ctl_wr;
  assign slot_we   = accept;
  assign pass_done = accept && last_slot;
  assign cv_start  = (state == ST_ISSUE) && !lp_req && !cv_busy && !ctl_wr;
  assign cv_chan   = mult ? {csel[CHW-1:SW], slot} : csel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= '0;
    end else if (ctl_wr) begin
      state <= ST_ISSUE;
      slot  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_IDLE;
        ST_ISSUE: begin
          if (lp_req)        state <= ST_SUSP;
          else if (!cv_busy) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (lp_req) begin
            state <= ST_SUSP;
          end else if (cv_done) begin
            if (last_slot) begin
              slot  <= '0;
              state <= scan ? ST_ISSUE : ST_IDLE;
            end else begin
              slot  <= slot + SW'(1);
              state <= ST_ISSUE;
            end
          end
        end
        ST_SUSP: if (!lp_req) state <= ST_ISSUE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int DW    = 8,
  parameter int NSLOT = 4,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [SW-1:0]             idx,
  input  logic [DW-1:0]             din,
  output logic [NSLOT-1:0][DW-1:0]  res
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                        res[g] <= '0;
      else if (we && idx == SW'(g))      res[g] <= din;
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int CHW   = 4,
  parameter int NSLOT = 4,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           lp_req,
  output logic           cv_start,
  output logic [CHW-1:0] cv_chan,
  input  logic           cv_busy,
  input  logic           cv_done,
  input  logic [DW-1:0]  cv_data
);
  import adc_seq_pkg::*;

  logic                     ctl_wr;
  logic                     scan_q;
  logic                     mult_q;
  logic [CHW-1:0]           csel_q;
  logic                     flag_q;
  logic                     pass_done;
  logic [SW-1:0]            slot;
  logic                     slot_we;
  logic [NSLOT-1:0][DW-1:0] res;

  adc_ctl_reg #(.AW(AW), .DW(DW), .CHW(CHW)) i_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pass_done(pass_done), .ctl_wr(ctl_wr),
    .scan(scan_q), .mult(mult_q), .csel(csel_q), .flag(flag_q)
  );

  adc_seq_fsm #(.CHW(CHW), .NSLOT(NSLOT)) i_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .scan(scan_q),
    .mult(mult_q), .csel(csel_q), .lp_req(lp_req), .cv_busy(cv_busy),
    .cv_done(cv_done), .cv_start(cv_start), .cv_chan(cv_chan),
    .slot(slot), .slot_we(slot_we), .pass_done(pass_done)
  );

  adc_result_bank #(.DW(DW), .NSLOT(NSLOT)) i_bank (
    .clk(clk), .rst_n(rst_n), .we(slot_we), .idx(slot),
    .din(cv_data), .res(res)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(CTL_ADDR))
      bus_rdata = DW'({flag_q, 1'b0, scan_q, mult_q, csel_q});
    for (int i = 0; i < NSLOT; i++)
      if (bus_addr == AW'(i + 1)) bus_rdata = res[i];
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CHW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_wr,
  input logic           flag,
  input logic           scan,
  input logic           mult,
  input logic [CHW-1:0] csel,
  input logic           lp_req,
  input logic           cv_start,
  input logic           cv_busy,
  input logic [CHW-1:0] cv_chan
);
  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cv_start |-> !cv_busy); // R8
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cv_start |=> !cv_start); // R8
  AST_LP_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |-> !cv_start); // R9
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !flag); // R3
  AST_SCAN_FLAG_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (scan && flag && !ctl_wr) |=> flag); // R6
  AST_ONESHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan && flag && !ctl_wr) |-> !cv_start); // R4
  AST_FIXED_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_start && !mult) |-> (cv_chan == csel)); // R7
endmodule

bind adc_seq_top adc_seq_chk #(.CHW(CHW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .flag(flag_q),
  .scan(scan_q), .mult(mult_q), .csel(csel_q), .lp_req(lp_req),
  .cv_start(cv_start), .cv_busy(cv_busy), .cv_chan(cv_chan)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  localparam int LAT = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       lp_req = 1'b0;
  logic       cv_start;
  logic [3:0] cv_chan;
  logic       cv_busy = 1'b0;
  logic       cv_done = 1'b0;
  logic [7:0] cv_data = '0;

  always #4 clk = ~clk;

  adc_seq_top i_adc_seq_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lp_req(lp_req),
    .cv_start(cv_start), .cv_chan(cv_chan), .cv_busy(cv_busy),
    .cv_done(cv_done), .cv_data(cv_data)
  );

  int checks = 0;
  int fails  = 0;
  int exp_ch[$];
  logic [7:0] log_q[$];
  logic [3:0] lat_cnt = '0;
  logic [7:0] pend = '0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: fixed latency, data = {channel, start index}
  always @(posedge clk) begin
    cv_done <= 1'b0;
    if (!rst_n) begin
      cv_busy <= 1'b0;
    end else if (cv_start) begin
      cv_busy <= 1'b1;
      lat_cnt <= 4'(LAT);
      pend    <= {cv_chan, 4'(log_q.size())};
      log_q.push_back({cv_chan, 4'(log_q.size())});
    end else if (cv_busy) begin
      if (lat_cnt == 4'd1) begin
        cv_busy <= 1'b0;
        cv_done <= 1'b1;
        cv_data <= pend;
      end
      lat_cnt <= lat_cnt - 4'd1;
    end
  end

  // scoreboard monitor: channel of every start against the expected queue
  always @(negedge clk) begin
    if (rst_n && cv_start) begin
      if (exp_ch.size() == 0) chk("R7 unexpected start", int'(cv_chan), -1);
      else chk("R7 channel", int'(cv_chan), exp_ch.pop_front());
    end
  end

  task automatic push_ch(int ch, int n);
    for (int i = 0; i < n; i++) exp_ch.push_back(ch);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_flag();
    logic [7:0] v;
    do rd(3'd0, v); while (!v[7]);
  endtask

  task automatic wait_starts(int n);
    while (log_q.size() < n) @(negedge clk);
  endtask

  task automatic check_slots(string req, int b0, int b1, int b2, int b3);
    logic [7:0] v;
    rd(3'd1, v); chk(req, v, log_q[b0]);
    rd(3'd2, v); chk(req, v, log_q[b1]);
    rd(3'd3, v); chk(req, v, log_q[b2]);
    rd(3'd4, v); chk(req, v, log_q[b3]);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] prev;
    int b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 4; a++) begin
      rd(3'(a), v); chk("R1 reset readback", v, 0);
    end
    repeat (10) @(negedge clk);
    chk("R1 no start after reset", log_q.size(), 0);

    // R4 single shot, fixed channel 5
    b = log_q.size();
    push_ch(5, 4);
    wr(3'd0, 8'h05);
    rd(3'd0, v); chk("R2 readback during run", v, 8'h05);
    wait_flag();
    check_slots("R4 slot order", b, b+1, b+2, b+3);
    rd(3'd0, v); chk("R6 flag after pass", v, 8'h85);
    repeat (40) @(negedge clk);
    chk("R4 halt after four", log_q.size(), b + 4);

    // R7 grouped channels 8..11
    b = log_q.size();
    push_ch(8, 1); push_ch(9, 1); push_ch(10, 1); push_ch(11, 1);
    wr(3'd0, 8'h1A);
    wait_flag();
    check_slots("R7 group results", b, b+1, b+2, b+3);
    rd(3'd0, v); chk("R6 flag grouped", v, 8'h9A);

    // R5 continuous scan over 12..15, then abort (R3)
    b = log_q.size();
    push_ch(12, 1); push_ch(13, 1); push_ch(14, 1); push_ch(15, 1);
    push_ch(12, 1); push_ch(13, 1); push_ch(14, 1);
    wr(3'd0, 8'h3C);
    wait_starts(b + 7);
    rd(3'd1, v); chk("R5 fifth into slot1", v, log_q[b+4]);
    rd(3'd2, v); chk("R5 sixth into slot2", v, log_q[b+5]);
    rd(3'd0, v); chk("R6 flag held in scan", v, 8'hBC);
    push_ch(4, 4);
    wr(3'd0, 8'h04);
    rd(3'd0, v); chk("R3 write clears flag", v, 8'h04);
    wait_starts(b + 8);
    rd(3'd3, v); chk("R3 aborted result dropped", v, log_q[b+2]);
    wait_flag();
    check_slots("R3 restart from slot1", b+7, b+8, b+9, b+10);

    // R9 low-power suspend and resample
    rd(3'd2, prev);
    b = log_q.size();
    push_ch(6, 5);
    wr(3'd0, 8'h06);
    wait_starts(b + 2);
    @(negedge clk);
    lp_req = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9 no start while suspended", log_q.size(), b + 2);
    rd(3'd2, v); chk("R9 in-flight result dropped", v, prev);
    @(negedge clk);
    lp_req = 1'b0;
    wait_flag();
    check_slots("R9 same slot resampled", b, b+2, b+3, b+4);

    // R2 ignored top bits, R10 read-only slots
    b = log_q.size();
    push_ch(7, 4);
    wr(3'd0, 8'hC7);
    rd(3'd0, v); chk("R2 bits 7:6 ignored", v, 8'h07);
    wait_flag();
    rd(3'd2, prev);
    wr(3'd2, 8'hFF);
    rd(3'd2, v); chk("R10 slot write ignored", v, prev);
    rd(3'd0, v); chk("R10 control untouched", v, 8'h87);
    repeat (40) @(negedge clk);
    chk("R10 no start from slot write", log_q.size(), b + 4);
    rd(3'd5, v); chk("R10 unmapped reads zero", v, 0);

    chk("R7 all expected starts seen", exp_ch.size(), 0);
    summary();
    $finish;
  end
endmodule